// File: doc/BRIEF.md
# Timeslot HDLC Frame Transmitter

This block turns bytes written by a host into a serial bitstream and places that stream into a small part of a T1-style line frame. Each frame has 193 bit times: one framing bit, then 24 channel time slots of eight bits each. One time slot is chosen by configuration. An eight-bit mask picks which bit positions inside that slot carry the stream. A frame-parity setting limits transmission to even frames, odd frames, or both. Every other bit time carries a fixed one and uses no stream bits.

In HDLC mode the host writes payload bytes into a 128-entry FIFO and tags the last byte of each frame. The transmitter then builds the frame. It opens with a flag, sends the data least significant bit first, appends a CRC-16 frame check sequence, inserts a zero after every run of five ones in the data and check fields, and closes with a flag. While no frame is pending the line carries timefill, which is either continuous flags or all ones. If the FIFO runs dry in the middle of a frame, the transmitter aborts the frame and raises an underrun strobe. In transparent mode the FIFO bytes go out unchanged and the end-of-frame tags are ignored.

The line side supplies a bit-time enable and a strobe that marks the framing bit. The first such strobe after reset starts frame 0, which counts as an even frame.

Top module: `tsx_hdlc_tx`

## Requirements
- R1: After reset, `tx_bit` is 1, `fifo_full` is 0 and `underrun` is 0. No stream bit is carried before the first `frame_start`. The first eight stream bits carried after reset are all ones.
- R2: A bit time with `bit_en` and `frame_start` both high is position 0 of a 193-bit frame. Slot s occupies positions 1+8s through 8+8s, and bit j of slot s sits at position 1+8s+j. Every position outside the slot set by `cfg_slot` drives `tx_bit` = 1.
- R3: Within the selected slot, bit j carries the next stream bit only when `cfg_mask[j]` is 1. Bit positions whose mask bit is 0 drive 1 and consume no stream bit.
- R4: `cfg_frames` = 0 transmits in every frame, 1 in even frames only, and 2 in odd frames only. The frame that starts at the first `frame_start` after reset is frame 0.
- R5: In HDLC mode (`cfg_transparent` = 0), a frame is sent as: flag 0x7E, the payload bytes each least significant bit first, the 16-bit check sequence, then a closing flag 0x7E.
- R6: The check sequence is CRC-16 with generator x^16+x^12+x^5+1. It is processed reflected: the register is preset to 0xFFFF and data enter least significant bit first. The ones complement of the register is sent bit 0 first.
- R7: In HDLC mode, a 0 is inserted after every five consecutive 1s within the payload and check-sequence bits. This includes a run that ends on the last check bit. A stuffed zero consumes no payload bit.
- R8: With no frame pending in HDLC mode, the timefill is repeated 0x7E flags when `cfg_flag_fill` = 1 and all ones when it is 0.
- R9: In transparent mode, FIFO bytes are sent least significant bit first with no flags, check sequence or stuffing, and `wr_last` has no effect. When the FIFO is empty the line carries ones.
- R10: The FIFO holds 128 bytes. `fifo_full` is 1 while 128 bytes are held, and a write while full is dropped.
- R11: If the FIFO is empty when a non-final payload byte has been sent, the transmitter sends eight ones, pulses `underrun` for one clock, and then returns to timefill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte into the FIFO |
| wr_data | input | 8 | Byte to write |
| wr_last | input | 1 | Written byte ends an HDLC frame |
| fifo_full | output | 1 | FIFO holds 128 bytes |
| cfg_slot | input | 5 | Selected time slot, 0 to 23 |
| cfg_frames | input | 2 | Frame parity: 0 all, 1 even, 2 odd |
| cfg_mask | input | 8 | Enabled bit positions in the slot |
| cfg_transparent | input | 1 | 1 selects transparent mode |
| cfg_flag_fill | input | 1 | Timefill: 1 flags, 0 ones |
| bit_en | input | 1 | One line bit time in this clock |
| frame_start | input | 1 | Current bit time is the framing bit |
| tx_bit | output | 1 | Line bit for the current bit time |
| underrun | output | 1 | One-clock pulse on a frame abort |

## Verification
Four configurations are driven. The first uses a full mask in all frames of slot 0 with payload full of long one-runs, which separates correct stuffing and check sequence from bit-order errors. The second uses a sparse mask on the last slot in even frames only with flag timefill, which exposes any slot-boundary, mask or parity mistake, because a masked bit that consumed data would shift everything after it. A frame with no end tag then shows the abort run, the underrun pulse and the return to flags. A transparent run through every odd frame fills the FIFO past its depth, which shows the full flag, the dropped write and the raw byte order.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

   typedef enum logic [2:0] {
      ST_FILL,
      ST_OPEN,
      ST_DATA,
      ST_FCS,
      ST_STUFF,
      ST_CLOSE,
      ST_ABORT,
      ST_RAW
   } tx_state_e;

   localparam logic [7:0]  HDLC_FLAG   = 8'h7E;
   localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
   localparam logic [15:0] CRC_POLY_RF = 16'h8408;

   function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[0] ^ b;
      crc_bit = fb ? ((c >> 1) ^ CRC_POLY_RF) : (c >> 1);
   endfunction

endpackage

// File: rtl/tsx_fifo.sv
module tsx_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_inc, rp_inc;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wp_inc = wp + 1'b1;
         assign rp_inc = rp + 1'b1;
      end else begin : g_wrap
         assign wp_inc = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_inc = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_inc;
         if (do_pop)  rp <= rp_inc;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R10: a write into a full FIFO leaves the occupancy unchanged
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == $past(cnt)));

   // R10: occupancy never exceeds the depth
   a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

endmodule

// File: rtl/tsx_slot_gate.sv
module tsx_slot_gate #(
   parameter int SLOTS     = 24,
   parameter int SLOT_BITS = 8,
   localparam int SW       = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 frame_start,
   input  logic [SW-1:0]        cfg_slot,
   input  logic [1:0]           cfg_frames,
   input  logic [SLOT_BITS-1:0] cfg_mask,
   output logic                 take
);
   localparam int FRAME_BITS = 1 + SLOTS * SLOT_BITS;
   localparam int PW = $clog2(FRAME_BITS + SLOT_BITS + 1);
   localparam int IW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

   logic [PW-1:0] pos_q, cur_pos, base, diff;
   logic [IW-1:0] idx;
   logic          odd_q, cur_odd, synced_q, in_slot, par_ok, mask_hit;

   assign cur_pos  = frame_start ? '0 : pos_q;
   assign cur_odd  = frame_start ? ~odd_q : odd_q;
   assign base     = PW'(1) + PW'(cfg_slot) * PW'(SLOT_BITS);
   assign in_slot  = (cur_pos >= base) && (cur_pos < base + PW'(SLOT_BITS));
   assign diff     = cur_pos - base;
   assign idx      = diff[IW-1:0];
   assign mask_hit = in_slot && cfg_mask[idx];

   always_comb begin
      case (cfg_frames)
         2'd0:    par_ok = 1'b1;
         2'd1:    par_ok = !cur_odd;
         2'd2:    par_ok = cur_odd;
         default: par_ok = 1'b0;
      endcase
   end

   assign take = bit_en && (synced_q || frame_start) && mask_hit && par_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         odd_q    <= 1'b1;
         synced_q <= 1'b0;
      end else if (bit_en) begin
         pos_q <= (cur_pos == PW'(FRAME_BITS - 1)) ? '0 : cur_pos + 1'b1;
         if (frame_start) begin
            odd_q    <= cur_odd;
            synced_q <= 1'b1;
         end
      end
   end

   // R4: frame parity alternates at every framing bit
   a_r4_parity_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && frame_start) |=> (odd_q != $past(odd_q)));

   // R2: a stream bit is only consumed in a line bit time
   a_r2_take_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> bit_en);

endmodule

// File: rtl/tsx_hdlc_enc.sv
module tsx_hdlc_enc
   import tsx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       cfg_transparent,
   input  logic       cfg_flag_fill,
   input  logic [7:0] head_data,
   input  logic       head_last,
   input  logic       empty,
   output logic       pop,
   output logic       enc_bit,
   output logic       underrun
);
   tx_state_e   st, st_d;
   logic [15:0] sh, sh_d, crc, crc_d, crc_nx;
   logic [4:0]  n, n_d;
   logic [2:0]  ones, ones_d, ones_nx;
   logic        cur_last, cur_last_d, und_d, stuff_now, in_field;
   logic [7:0]  fill_byte;

   assign fill_byte = cfg_flag_fill ? HDLC_FLAG : 8'hFF;
   assign in_field  = (st == ST_DATA) || (st == ST_FCS);
   assign stuff_now = in_field && (ones == 3'd5);
   assign enc_bit   = stuff_now ? 1'b0 : sh[0];
   assign crc_nx    = crc_bit(crc, sh[0]);
   assign ones_nx   = sh[0] ? ones + 3'd1 : 3'd0;

   always_comb begin
      st_d       = st;
      sh_d       = sh;
      n_d        = n;
      ones_d     = ones;
      crc_d      = crc;
      cur_last_d = cur_last;
      und_d      = 1'b0;
      pop        = 1'b0;
      if (take) begin
         if (stuff_now) begin
            ones_d = 3'd0;
         end else begin
            sh_d   = sh >> 1;
            n_d    = n - 5'd1;
            ones_d = in_field ? ones_nx : 3'd0;
            if (st == ST_DATA) crc_d = crc_nx;
            if (n == 5'd1) begin
               n_d = 5'd8;
               case (st)
                  ST_DATA: begin
                     if (cur_last) begin
                        st_d = ST_FCS;
                        sh_d = ~crc_nx;
                        n_d  = 5'd16;
                     end else if (!empty) begin
                        pop        = 1'b1;
                        sh_d       = {8'h00, head_data};
                        cur_last_d = head_last;
                     end else begin
                        st_d  = ST_ABORT;
                        sh_d  = 16'h00FF;
                        und_d = 1'b1;
                     end
                  end
                  ST_FCS: begin
                     if (ones_nx == 3'd5) begin
                        st_d = ST_STUFF;
                        sh_d = 16'h0000;
                        n_d  = 5'd1;
                     end else begin
                        st_d = ST_CLOSE;
                        sh_d = {8'h00, HDLC_FLAG};
                     end
                  end
                  ST_STUFF: begin
                     st_d = ST_CLOSE;
                     sh_d = {8'h00, HDLC_FLAG};
                  end
                  ST_OPEN: begin
                     pop        = 1'b1;
                     st_d       = ST_DATA;
                     sh_d       = {8'h00, head_data};
                     cur_last_d = head_last;
                     crc_d      = CRC_PRESET;
                     ones_d     = 3'd0;
                  end
                  default: begin
                     if (cfg_transparent) begin
                        if (!empty) begin
                           pop  = 1'b1;
                           st_d = ST_RAW;
                           sh_d = {8'h00, head_data};
                        end else begin
                           st_d = ST_FILL;
                           sh_d = 16'h00FF;
                        end
                     end else if (!empty) begin
                        st_d = ST_OPEN;
                        sh_d = {8'h00, HDLC_FLAG};
                     end else begin
                        st_d = ST_FILL;
                        sh_d = {8'h00, fill_byte};
                     end
                  end
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_FILL;
         sh       <= 16'h00FF;
         n        <= 5'd8;
         ones     <= 3'd0;
         crc      <= CRC_PRESET;
         cur_last <= 1'b0;
         underrun <= 1'b0;
      end else begin
         st       <= st_d;
         sh       <= sh_d;
         n        <= n_d;
         ones     <= ones_d;
         crc      <= crc_d;
         cur_last <= cur_last_d;
         underrun <= und_d;
      end
   end

   // R7: a stuffed zero holds the pending payload bits
   a_r7_stuff_holds_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (take && stuff_now) |=> ($stable(sh) && $stable(n)));

   // R7: runs of ones inside the fields never exceed five
   a_r7_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= 3'd5);

   // R11: an underrun pulse coincides with the abort run
   a_r11_underrun_in_abort: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (st == ST_ABORT));

   // R11: the underrun strobe lasts one clock
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> !underrun);

endmodule

// File: rtl/tsx_hdlc_tx.sv
module tsx_hdlc_tx #(
   parameter int SLOTS     = 24,
   parameter int SLOT_BITS = 8,
   parameter int DEPTH     = 128,
   localparam int SW       = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [7:0]           wr_data,
   input  logic                 wr_last,
   output logic                 fifo_full,
   input  logic [SW-1:0]        cfg_slot,
   input  logic [1:0]           cfg_frames,
   input  logic [SLOT_BITS-1:0] cfg_mask,
   input  logic                 cfg_transparent,
   input  logic                 cfg_flag_fill,
   input  logic                 bit_en,
   input  logic                 frame_start,
   output logic                 tx_bit,
   output logic                 underrun
);
   localparam int ENTRY_W = 9;

   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("tsx_hdlc_tx: SLOTS must be at least 1");
      end
      if (SLOT_BITS < 1) begin : g_bad_bits
         $error("tsx_hdlc_tx: SLOT_BITS must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("tsx_hdlc_tx: DEPTH must be at least 2");
      end
   endgenerate

   logic               take, pop, empty, enc_bit;
   logic [ENTRY_W-1:0] head;

   tsx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_en),
      .din   ({wr_last, wr_data}),
      .pop   (pop),
      .dout  (head),
      .empty (empty),
      .full  (fifo_full)
   );

   tsx_slot_gate #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .frame_start (frame_start),
      .cfg_slot    (cfg_slot),
      .cfg_frames  (cfg_frames),
      .cfg_mask    (cfg_mask),
      .take        (take)
   );

   tsx_hdlc_enc u_enc (
      .clk             (clk),
      .rst_n           (rst_n),
      .take            (take),
      .cfg_transparent (cfg_transparent),
      .cfg_flag_fill   (cfg_flag_fill),
      .head_data       (head[7:0]),
      .head_last       (head[8]),
      .empty           (empty),
      .pop             (pop),
      .enc_bit         (enc_bit),
      .underrun        (underrun)
   );

   assign tx_bit = take ? enc_bit : 1'b1;

   // R2, R3: bit times that carry no stream bit hold the line at one
   a_r3_fill_outside: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> tx_bit);

   // R10: the FIFO is only drained while a stream bit is consumed
   a_r10_pop_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> take);

endmodule

// File: tb/tsx_hdlc_tx_bench.sv
module tsx_hdlc_tx_bench;
   localparam int FRAME_BITS = 193;
   localparam int LIMIT      = 195000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wr_last = 1'b0;
   logic       fifo_full;
   logic [4:0] cfg_slot = 5'd0;
   logic [1:0] cfg_frames = 2'd0;
   logic [7:0] cfg_mask = 8'hFF;
   logic       cfg_transparent = 1'b0;
   logic       cfg_flag_fill = 1'b0;
   logic       bit_en = 1'b0;
   logic       frame_start = 1'b0;
   logic       tx_bit;
   logic       underrun;

   tsx_hdlc_tx u_tsx_hdlc_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
      .fifo_full(fifo_full), .cfg_slot(cfg_slot), .cfg_frames(cfg_frames),
      .cfg_mask(cfg_mask), .cfg_transparent(cfg_transparent),
      .cfg_flag_fill(cfg_flag_fill), .bit_en(bit_en), .frame_start(frame_start),
      .tx_bit(tx_bit), .underrun(underrun)
   );

   always #2.5 clk = ~clk;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;
   bit run = 0;
   int tb_pos = -1;
   int fnum = -1;
   int cap_n = 0;
   int fill_err = 0;
   int und_cnt = 0;
   bit cap [0:4095];
   bit exp_b [0:4095];
   int exp_n = 0;
   int stuff_run = 0;
   logic [15:0] crc_m;

   // line frame generator, driven just after the active edge
   always @(posedge clk) begin
      #1;
      if (!run) begin
         tb_pos = -1;
         fnum = -1;
         frame_start = 1'b0;
         bit_en = 1'b0;
      end else begin
         tb_pos = (tb_pos + 1) % FRAME_BITS;
         if (tb_pos == 0) fnum = fnum + 1;
         frame_start = (tb_pos == 0);
         bit_en = 1'b1;
      end
   end

   // monitor on the falling edge
   always @(negedge clk) begin
      if (rst_n && underrun) und_cnt = und_cnt + 1;
      if (run && tb_pos >= 0) begin
         int s, j;
         bit par, want;
         s = (tb_pos - 1) / 8;
         j = (tb_pos - 1) % 8;
         par = (cfg_frames == 2'd0) || (cfg_frames == 2'd1 && fnum % 2 == 0) ||
               (cfg_frames == 2'd2 && fnum % 2 == 1);
         want = (tb_pos >= 1) && (s == int'(cfg_slot)) && cfg_mask[j] && par;
         if (want) begin
            if (cap_n < 4096) cap[cap_n] = tx_bit;
            cap_n = cap_n + 1;
         end else if (tx_bit !== 1'b1) begin
            fill_err = fill_err + 1;
         end
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > LIMIT) begin
         fails = fails + 1;
         $display("FAIL watchdog: act cycles=%0d exp below %0d", cyc, LIMIT);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      vectors = vectors + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
      end
   endtask

   task automatic do_reset(input int slot, input int frames, input int mask,
                           input bit transp, input bit flags);
      run = 0;
      rst_n = 1'b0;
      cfg_slot = slot[4:0];
      cfg_frames = frames[1:0];
      cfg_mask = mask[7:0];
      cfg_transparent = transp;
      cfg_flag_fill = flags;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      cap_n = 0;
      fill_err = 0;
      und_cnt = 0;
      exp_n = 0;
   endtask

   task automatic put(input logic [7:0] b, input bit last);
      wr_en = 1'b1;
      wr_data = b;
      wr_last = last;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      wr_last = 1'b0;
   endtask

   task automatic e_raw(input logic [7:0] b);
      for (int k = 0; k < 8; k++) begin
         exp_b[exp_n] = b[k];
         exp_n = exp_n + 1;
      end
   endtask

   task automatic e_field(input bit b);
      exp_b[exp_n] = b;
      exp_n = exp_n + 1;
      stuff_run = b ? stuff_run + 1 : 0;
      if (stuff_run == 5) begin
         exp_b[exp_n] = 1'b0;
         exp_n = exp_n + 1;
         stuff_run = 0;
      end
   endtask

   task automatic e_byte(input logic [7:0] b);
      for (int k = 0; k < 8; k++) begin
         bit fb;
         fb = crc_m[0] ^ b[k];
         crc_m = crc_m >> 1;
         if (fb) crc_m = crc_m ^ 16'h8408;
         e_field(b[k]);
      end
   endtask

   task automatic e_fcs_close();
      logic [15:0] f;
      f = ~crc_m;
      for (int k = 0; k < 16; k++) e_field(f[k]);
      e_raw(8'h7E);
   endtask

   task automatic e_open();
      e_raw(8'hFF);
      e_raw(8'h7E);
      crc_m = 16'hFFFF;
      stuff_run = 0;
   endtask

   task automatic collect(input int need);
      int t;
      t = 0;
      while (cap_n < need && t < 60000) begin
         @(posedge clk);
         t = t + 1;
      end
      #1;
   endtask

   task automatic cmp_stream(input string req);
      int bad, first;
      bad = 0;
      first = -1;
      for (int i = 0; i < exp_n; i++) begin
         if (i >= cap_n || cap[i] != exp_b[i]) begin
            bad = bad + 1;
            if (first < 0) first = i;
         end
      end
      chk(bad == 0, req, first, -1);
   endtask

   task automatic cmp_tail(input string req, input logic [7:0] pat);
      int bad;
      bad = 0;
      for (int i = 0; i < 16; i++)
         if (exp_n + i >= cap_n || cap[exp_n + i] != pat[i % 8]) bad = bad + 1;
      chk(bad == 0, req, bad, 0);
   endtask

   initial begin
      // R1: reset state
      do_reset(0, 0, 8'hFF, 1'b0, 1'b0);
      #1;
      chk(tx_bit === 1'b1, "R1 tx_bit after reset", tx_bit, 1);
      chk(fifo_full === 1'b0, "R1 fifo_full after reset", fifo_full, 0);
      chk(underrun === 1'b0, "R1 underrun after reset", underrun, 0);

      // Test A: slot 0, full mask, all frames, ones fill; R5 R6 R7 R8
      put(8'hFF, 0); put(8'h7E, 0); put(8'h01, 0); put(8'hF8, 1);
      repeat (20) @(posedge clk);
      #1;
      chk(tx_bit === 1'b1, "R1 idle before first frame_start", tx_bit, 1);
      e_open();
      e_byte(8'hFF); e_byte(8'h7E); e_byte(8'h01); e_byte(8'hF8);
      e_fcs_close();
      run = 1;
      collect(exp_n + 16);
      cmp_stream("R5 R6 R7 stuffed frame slot0");
      cmp_tail("R8 ones timefill", 8'hFF);
      chk(fill_err == 0, "R2 unused positions at one", fill_err, 0);
      chk(und_cnt == 0, "R11 no underrun on complete frame", und_cnt, 0);

      // Test B: last slot, sparse mask, even frames, flag fill; R2 R3 R4 R8
      do_reset(23, 1, 8'h5A, 1'b0, 1'b1);
      put(8'h55, 0); put(8'hFF, 0); put(8'hFF, 1);
      e_open();
      e_byte(8'h55); e_byte(8'hFF); e_byte(8'hFF);
      e_fcs_close();
      run = 1;
      collect(exp_n + 16);
      cmp_stream("R3 R4 masked even-frame stream slot23");
      cmp_tail("R8 flag timefill", 8'h7E);
      chk(fill_err == 0, "R3 masked and odd-frame bits at one", fill_err, 0);

      // Test C: underrun, flag fill; R11
      do_reset(5, 0, 8'hFF, 1'b0, 1'b1);
      put(8'h0F, 0); put(8'h12, 0);
      e_open();
      e_byte(8'h0F); e_byte(8'h12);
      e_raw(8'hFF);
      run = 1;
      collect(exp_n + 16);
      cmp_stream("R11 abort run after underrun");
      cmp_tail("R11 flag timefill after abort", 8'h7E);
      chk(und_cnt == 1, "R11 single underrun pulse", und_cnt, 1);
      chk(fill_err == 0, "R2 slot5 other positions at one", fill_err, 0);

      // Test D: transparent, odd frames, overfill; R9 R10
      do_reset(11, 2, 8'hFF, 1'b1, 1'b1);
      for (int i = 0; i < 128; i++) put(8'((i * 37 + 5) & 255), (i % 3) == 0);
      #1;
      chk(fifo_full === 1'b1, "R10 full at 128 bytes", fifo_full, 1);
      put(8'hA5, 0);
      chk(fifo_full === 1'b1, "R10 still full after dropped write", fifo_full, 1);
      e_raw(8'hFF);
      for (int i = 0; i < 128; i++) e_raw(8'((i * 37 + 5) & 255));
      run = 1;
      collect(exp_n + 16);
      cmp_stream("R9 R10 raw bytes, dropped write absent");
      cmp_tail("R9 ones when empty", 8'hFF);
      chk(fifo_full === 1'b0, "R10 full clears after drain", fifo_full, 0);
      chk(fill_err == 0, "R4 even-frame bits at one", fill_err, 0);
      chk(und_cnt == 0, "R9 no underrun in transparent mode", und_cnt, 0);

      run = 0;
      summary();
   end

endmodule